// File: doc/BRIEF.md
# Floppy Drive Select and Ready Monitor

This block sits between a floppy disk controller and up to four drives. While a command runs with the head loaded, it turns a two-bit unit number into one active select line and holds it for the whole access. While the controller is idle, it polls the drives one at a time, round-robin. Each poll opens a short select window and ends by sampling that drive's ready line.

Each sample is compared with the last sample kept for the same drive. A difference latches a per-drive pending-change flag, and the OR of the flags forms an interrupt. The CPU clears flags with a one-cycle acknowledge mask. This lets software see a disk being inserted or removed.

The select line of drive 3 is built differently so that polling never flashes its front-panel lamp. It is the OR of a CPU port bit and a one-shot that is held during an access to drive 3 and stretched a fixed time after it. Scan windows never reach this line.

Top module: `fdd_select_monitor`

## Requirements
- R1: After reset, `sel_out`, `change_pend` and `ready_state` are all zero and `irq` is low.
- R2: While `busy` and `head_load` are both high, unit number u drives `sel_out[u]` high (bit u of the 4-bit output) and no other bit of `sel_out[2:0]`, for as long as both stay high.
- R3: While `busy` is low, every SCAN_TICKS cycles one drive is polled, in the order 0,1,2,3,0. For drives 0 to 2, the drive's `sel_out` bit is high during the last PULSE_TICKS cycles of its interval. The drive's ready line is sampled into `ready_state` at the last edge of the interval.
- R4: The first poll of each drive after reset only stores its ready state and sets no pending flag.
- R5: From the second poll on, a sample that differs from the stored one sets that drive's `change_pend` bit. `irq` is high whenever any `change_pend` bit is set.
- R6: A one-cycle `ack` pulse clears the `change_pend` bits given by its mask. If a change is detected for a drive in the same cycle as its acknowledge, the flag stays set.
- R7: While `busy` is high, no poll takes place: `ready_state` and `change_pend` keep their values, and no select comes from scanning. After `busy` falls, the next poll comes a full SCAN_TICKS cycles later.
- R8: `sel_out[3]` never goes high because of a poll. After an access to drive 3 ends, it stays high for exactly STRETCH_TICKS more cycles.
- R9: `port_sel3` high forces `sel_out[3]` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Controller is executing a command |
| head_load | input | 1 | Head-load request from the controller |
| unit_sel | input | 2 | Unit number of the drive being accessed |
| ready_in | input | 4 | Ready line of each drive |
| port_sel3 | input | 1 | CPU port bit for drive 3 select |
| ack | input | 4 | One-cycle clear mask for pending-change flags |
| sel_out | output | 4 | Select line for each drive |
| change_pend | output | 4 | Latched pending-change flag for each drive |
| irq | output | 1 | State-change interrupt |
| ready_state | output | 4 | Last sampled ready state of each drive |

## Verification
Change detection and the CPU acknowledge can land on the same clock edge and touch the same flag register. The bench provokes this by flipping every ready line and then asserting an all-ones `ack` on exactly the edge that ends a poll interval. The expected result is that the flag found by that poll survives while the earlier flag is cleared. A second collision can occur when `busy` falls mid-interval: the bench checks that the poll waits a full SCAN_TICKS cycles and does not reuse the partly counted interval.

// File: rtl/fdd_select_monitor.sv
module fdd_select_monitor #(
  parameter int SCAN_TICKS    = 50000,
  parameter int PULSE_TICKS   = 16,
  parameter int STRETCH_TICKS = 1500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       head_load,
  input  logic [1:0] unit_sel,
  input  logic [3:0] ready_in,
  input  logic       port_sel3,
  input  logic [3:0] ack,
  output logic [3:0] sel_out,
  output logic [3:0] change_pend,
  output logic       irq,
  output logic [3:0] ready_state
);
  localparam int CW = $clog2(SCAN_TICKS);
  localparam int SW = $clog2(STRETCH_TICKS + 1);

  logic [CW-1:0] tick;
  logic [1:0]    ptr;
  logic [3:0]    seen;
  logic [3:0]    state_q;
  logic [3:0]    pend_q;
  logic [SW-1:0] hold3;

  wire       scan_win = !busy && (tick >= CW'(SCAN_TICKS - PULSE_TICKS));
  wire       scan_hit = !busy && (tick == CW'(SCAN_TICKS - 1));
  wire       access   = busy && head_load;
  wire [3:0] acc_dec  = access   ? (4'b0001 << unit_sel) : 4'b0000;
  wire [3:0] scan_dec = scan_win ? (4'b0001 << ptr)      : 4'b0000;
  wire [3:0] load     = scan_hit ? (4'b0001 << ptr)      : 4'b0000;
  wire [3:0] flip     = load & seen & (state_q ^ ready_in);

  assign sel_out     = {port_sel3 | acc_dec[3] | (hold3 != '0),
                        acc_dec[2:0] | scan_dec[2:0]};
  assign change_pend = pend_q;
  assign irq         = |pend_q;
  assign ready_state = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick    <= '0;
      ptr     <= '0;
      seen    <= '0;
      state_q <= '0;
      pend_q  <= '0;
      hold3   <= '0;
    end else begin
      if (busy || scan_hit) tick <= '0;
      else                  tick <= tick + 1'b1;
      if (scan_hit) ptr <= ptr + 1'b1;
      seen    <= seen | load;
      state_q <= (state_q & ~load) | (ready_in & load);
      pend_q  <= (pend_q & ~ack) | flip;
      if (acc_dec[3])         hold3 <= SW'(STRETCH_TICKS);
      else if (hold3 != '0)   hold3 <= hold3 - 1'b1;
    end
  end

  assert_access_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && head_load && unit_sel != 2'd3) |-> (sel_out[unit_sel] && $countones(sel_out[2:0]) == 1));

  assert_busy_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ready_state) && ((change_pend & ~$past(change_pend)) == 4'b0000)));

  assert_busy_no_scan_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !head_load) |-> (sel_out[2:0] == 3'b000));

  assert_scan_no_lamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !port_sel3 && hold3 == '0) |-> !sel_out[3]);

  assert_port_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel3 |-> sel_out[3]);

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(|ack));

  assert_change_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(!busy));
endmodule

// File: tb/fdd_select_monitor_bench.sv
module fdd_select_monitor_bench;
  localparam int SCAN = 8, PULSE = 2, STR = 5;

  logic       clk = 1'b0, rst_n = 1'b0, busy = 1'b0, head_load = 1'b0, port_sel3 = 1'b0;
  logic [1:0] unit_sel = 2'd0;
  logic [3:0] ready_in = 4'h0, ack = 4'h0;
  logic [3:0] sel_out, change_pend, ready_state;
  logic       irq;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  fdd_select_monitor #(.SCAN_TICKS(SCAN), .PULSE_TICKS(PULSE), .STRETCH_TICKS(STR)) u_fdd_select_monitor (
    .clk(clk), .rst_n(rst_n), .busy(busy), .head_load(head_load), .unit_sel(unit_sel),
    .ready_in(ready_in), .port_sel3(port_sel3), .ack(ack), .sel_out(sel_out),
    .change_pend(change_pend), .irq(irq), .ready_state(ready_state));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] prev, old, pnow;
    step(3);
    chk("R1 sel_out", sel_out, 0);
    chk("R1 change_pend", change_pend, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ready_state", ready_state, 0);
    ready_in = 4'hF;
    rst_n = 1'b1;

    step(5); chk("R3 no pulse yet", sel_out, 0);
    step(1); chk("R3 drive0 pulse", sel_out, 4'b0001);
    step(2); chk("R4 drive0 stored", ready_state, 4'b0001);
    chk("R4 no flag", change_pend, 0);
    step(6); chk("R3 drive1 pulse", sel_out, 4'b0010);
    step(2); chk("R3 drive1 stored", ready_state, 4'b0011);
    step(6); chk("R3 drive2 pulse", sel_out, 4'b0100);
    step(2); chk("R3 drive2 stored", ready_state, 4'b0111);
    step(6); chk("R8 drive3 poll no select", sel_out, 0);
    step(2); chk("R4 drive3 stored", ready_state, 4'b1111);
    chk("R4 no flag after first round", change_pend, 0);
    chk("R4 irq low", irq, 0);

    prev = 4'hF;
    for (int v = 0; v < 16; v++) begin
      ready_in = 4'(v);
      step(4 * SCAN);
      chk("R5 pending mask", change_pend, prev ^ 4'(v));
      chk("R5 irq", irq, (prev != 4'(v)) ? 1 : 0);
      chk("R3 state after round", ready_state, v);
      ack = change_pend;
      step(1);
      ack = 4'h0;
      chk("R6 ack clears", change_pend, 0);
      prev = 4'(v);
    end

    busy = 1'b1; head_load = 1'b1;
    for (int u = 0; u < 4; u++) begin
      unit_sel = 2'(u);
      step(1);
      chk("R2 access select", sel_out, 1 << u);
    end
    head_load = 1'b0;
    #1 chk("R8 stretch start", sel_out, 4'b1000);
    step(STR - 1); chk("R8 stretch held", sel_out, 4'b1000);
    step(1); chk("R8 stretch ended", sel_out, 0);
    port_sel3 = 1'b1;
    step(1); chk("R9 port bit", sel_out, 4'b1000);
    port_sel3 = 1'b0;
    step(1); chk("R9 port bit released", sel_out, 0);

    ready_in = 4'h0;
    old = ready_state;
    step(5 * SCAN);
    chk("R7 state frozen", ready_state, old);
    chk("R7 no flag while busy", change_pend, 0);
    chk("R7 no scan select", sel_out, 0);

    busy = 1'b0;
    step(SCAN - 1); chk("R7 no early poll", ready_state, old);
    step(1);
    chk("R7 one poll after full interval", $countones(ready_state ^ old), 1);
    chk("R5 flag on that drive", change_pend, ready_state ^ old);
    pnow = change_pend;

    step(SCAN - 1);
    ack = 4'hF;
    step(1);
    ack = 4'h0;
    chk("R6 set wins over ack", $countones(change_pend), 1);
    chk("R6 old flag cleared", change_pend & pnow, 0);
    chk("R6 irq kept", irq, 1);
    ack = change_pend;
    step(1);
    ack = 4'h0;
    chk("R6 final clear", change_pend, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule